// File: doc/BRIEF.md
# Upstream Bus Request Controller

This block governs how a bridge competes for its upstream bus whenever it must act as an initiator there. It looks at how many entries sit fully queued in the two upstream queues (posted writes and delayed requests). It drives an active-low request line to the external arbiter and samples the active-low grant that comes back. From these it produces a one-cycle strobe that tells the bus transaction engine to begin. It also produces an enable that tells the pad logic to drive the shared address, command and parity lines to valid levels while the bus is parked on this block.

When an attempt ends with a retry, a disconnect or an abort, the controller steps back from the bus for two clocks before it asks again. A grant that arrives while nothing is being requested only parks the bus. If work shows up while the bus is parked and grant is still present, the transaction begins at once, without a separate request phase. The queues and the transaction engine are outside the block. They appear only as counts and as a termination pulse.

Top module: `up_req_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `req_n` = 1, `start` = 0 and `park_en` = 0.
- R2: `req_n` goes low one cycle after either `pw_cnt` or `dr_cnt` is sampled nonzero (with no back-off running). It goes high one cycle after both are sampled zero. Only these counts of completely queued entries count as pending work.
- R3: A `term_valid` pulse with `term_code` 1 (retry), 2 (disconnect) or 3 (abort) makes `req_n` high for exactly the two following cycles. After that it is low again if work is still pending.
- R4: A `term_valid` pulse with `term_code` 0 (normal completion) does not cause back-off, so `req_n` stays low while work is pending.
- R5: When `gnt_n` is sampled low while `req_n` is low, no back-off is running and no transfer is active, `start` is high in the next cycle and for that one cycle only.
- R6: A grant sampled during the two back-off cycles, or in the same cycle as the terminating pulse, never raises `start`.
- R7: When `gnt_n` is sampled low while `req_n` is high and no transfer is active, `park_en` goes high the next cycle. It goes low the cycle after `gnt_n` is sampled high.
- R8: While `park_en` is high, if work becomes pending and `gnt_n` is still low at that edge (and no back-off is running), `start` rises in the next cycle without a prior cycle of `req_n` low.
- R9: `park_en` and `start` are never high together. `start` does not rise again between a start and the `term_valid` pulse that ends that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pw_cnt | input | CNT_W | Number of completely queued upstream posted writes |
| dr_cnt | input | CNT_W | Number of completely queued upstream delayed requests |
| gnt_n | input | 1 | Grant from the upstream arbiter, active low |
| term_valid | input | 1 | One-cycle pulse marking the end of this block's transfer |
| term_code | input | 2 | Termination kind: 0 normal, 1 retry, 2 disconnect, 3 abort |
| req_n | output | 1 | Request to the upstream arbiter, active low |
| start | output | 1 | One-cycle strobe to begin the upstream transaction |
| park_en | output | 1 | Drive enable for address, command and parity while parked |

## Verification
A back-off counter stuck at a nonzero value shows as `req_n` held high while work is pending. A counter that reloads wrongly shows as a high window of one or three cycles instead of two. Either appears within three cycles of the termination pulse. A transfer-active flag that fails to clear keeps `start` low under a later grant. One that fails to set lets `start` pulse on every granted cycle. Both are visible on the cycle after the next grant. A parking flag that ignores `req_n` or grant turns into `park_en` overlapping `start`, or lingering one cycle after grant is removed.

// File: rtl/up_req_pkg.sv
package up_req_pkg;

  typedef enum logic [1:0] {
    TERM_DONE  = 2'd0,
    TERM_RETRY = 2'd1,
    TERM_DISC  = 2'd2,
    TERM_ABORT = 2'd3
  } term_e;

  function automatic logic needs_backoff(input term_e code);
    return code != TERM_DONE;
  endfunction

endpackage

// File: rtl/up_req_backoff.sv
module up_req_backoff #(
  parameter int BACKOFF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic idle,
  output logic idle_nxt
);
  localparam int BW = $clog2(BACKOFF_CYC + 1);

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;

  always_comb begin
    if (trig)
      cnt_d = BW'(BACKOFF_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign idle     = (cnt_q == '0);
  assign idle_nxt = (cnt_d == '0);
endmodule

// File: rtl/up_req_arb.sv
module up_req_arb (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic gnt_n,
  input  logic trig,
  input  logic term_valid,
  input  logic bo_idle,
  input  logic bo_idle_nxt,
  output logic req_n,
  output logic start,
  output logic park_en,
  output logic in_xfer
);
  logic start_d;
  logic xfer_d;
  logic park_d;
  logic req_n_d;

  always_comb begin
    start_d = !gnt_n && pending && bo_idle && !trig && !in_xfer && !start
              && (!req_n || park_en);
    if (start_d)         xfer_d = 1'b1;
    else if (term_valid) xfer_d = 1'b0;
    else                 xfer_d = in_xfer;
    req_n_d = !(pending && bo_idle_nxt);
    park_d  = !gnt_n && !start_d && !xfer_d && (req_n || park_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_n   <= 1'b1;
      start   <= 1'b0;
      park_en <= 1'b0;
      in_xfer <= 1'b0;
    end else begin
      req_n   <= req_n_d;
      start   <= start_d;
      park_en <= park_d;
      in_xfer <= xfer_d;
    end
  end
endmodule

// File: rtl/up_req_ctrl.sv
module up_req_ctrl #(
  parameter int CNT_W       = 4,
  parameter int BACKOFF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] pw_cnt,
  input  logic [CNT_W-1:0] dr_cnt,
  input  logic             gnt_n,
  input  logic             term_valid,
  input  logic [1:0]       term_code,
  output logic             req_n,
  output logic             start,
  output logic             park_en
);
  import up_req_pkg::*;

  logic pending;
  logic trig;
  logic bo_idle;
  logic bo_idle_nxt;
  logic xfer_busy;

  assign pending = (pw_cnt != '0) || (dr_cnt != '0);
  assign trig    = term_valid && needs_backoff(term_e'(term_code));

  up_req_backoff #(.BACKOFF_CYC(BACKOFF_CYC)) u_backoff (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .idle     (bo_idle),
    .idle_nxt (bo_idle_nxt)
  );

  up_req_arb u_arb (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .gnt_n       (gnt_n),
    .trig        (trig),
    .term_valid  (term_valid),
    .bo_idle     (bo_idle),
    .bo_idle_nxt (bo_idle_nxt),
    .req_n       (req_n),
    .start       (start),
    .park_en     (park_en),
    .in_xfer     (xfer_busy)
  );
endmodule

// File: rtl/up_req_ctrl_chk.sv
module up_req_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] pw_cnt,
  input logic [CNT_W-1:0] dr_cnt,
  input logic             gnt_n,
  input logic             term_valid,
  input logic [1:0]       term_code,
  input logic             req_n,
  input logic             start,
  input logic             park_en,
  input logic             xfer_busy
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (req_n && !start && !park_en)); // R1
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (pw_cnt == '0 && dr_cnt == '0) |=> req_n); // R2
  AST_BACKOFF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (term_valid && term_code != 2'd0) |=> req_n ##1 req_n); // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R5
  AST_BACKOFF_NO_START: assert property (@(posedge clk) disable iff (rst)
    (term_valid && term_code != 2'd0) |=> !start ##1 !start); // R6
  AST_PARK_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    gnt_n |=> !park_en); // R7
  AST_PARK_START_EXCL: assert property (@(posedge clk) disable iff (rst)
    park_en |-> !start); // R9
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    (xfer_busy && !term_valid) |=> !start); // R9
endmodule

bind up_req_ctrl up_req_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pw_cnt     (pw_cnt),
  .dr_cnt     (dr_cnt),
  .gnt_n      (gnt_n),
  .term_valid (term_valid),
  .term_code  (term_code),
  .req_n      (req_n),
  .start      (start),
  .park_en    (park_en),
  .xfer_busy  (xfer_busy)
);

// File: tb/up_req_ctrl_tb.sv
module up_req_ctrl_tb;
  localparam int CNT_W = 4;
  localparam int NV    = 25;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] pw_cnt = '0;
  logic [CNT_W-1:0] dr_cnt = '0;
  logic             gnt_n = 1'b1;
  logic             term_valid = 1'b0;
  logic [1:0]       term_code = 2'd0;
  logic             req_n;
  logic             start;
  logic             park_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  up_req_ctrl #(.CNT_W(CNT_W), .BACKOFF_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .pw_cnt(pw_cnt), .dr_cnt(dr_cnt), .gnt_n(gnt_n),
    .term_valid(term_valid), .term_code(term_code),
    .req_n(req_n), .start(start), .park_en(park_en)
  );

  // {pw_cnt, dr_cnt, gnt_n, term_valid, term_code, exp req_n, exp start, exp park_en}
  localparam logic [14:0] VEC [NV] = '{
    15'b0000_0000_1_0_00_100,  // 0  empty queues
    15'b0001_0000_1_0_00_000,  // 1  posted write ready
    15'b0001_0000_0_0_00_010,  // 2  grant -> start
    15'b0001_0000_0_0_00_000,  // 3  single pulse, busy
    15'b0001_0000_1_1_01_100,  // 4  retry
    15'b0001_0000_0_0_00_101,  // 5  back-off, grant parks only
    15'b0001_0000_1_0_00_000,  // 6  request back, park released
    15'b0001_0000_0_0_00_010,  // 7  start
    15'b0001_0000_1_1_00_000,  // 8  normal completion
    15'b0000_0000_1_0_00_100,  // 9  drained
    15'b0000_0010_1_0_00_000,  // 10 delayed request ready
    15'b0000_0010_0_0_00_010,  // 11 start
    15'b0000_0010_0_1_10_100,  // 12 disconnect under grant
    15'b0000_0010_0_0_00_101,  // 13 back-off with grant
    15'b0000_0010_0_0_00_001,  // 14 request back, still parked
    15'b0000_0010_0_0_00_010,  // 15 start, park drops
    15'b0000_0010_1_1_11_100,  // 16 abort
    15'b0000_0000_1_0_00_100,  // 17 back-off, empty
    15'b0000_0000_0_0_00_101,  // 18 park
    15'b0000_0000_0_0_00_101,  // 19 stay parked
    15'b0001_0000_0_0_00_010,  // 20 parked start
    15'b0001_0000_1_1_00_000,  // 21 normal completion
    15'b0000_0000_1_0_00_100,  // 22 drained
    15'b0000_0000_0_0_00_101,  // 23 park
    15'b0000_0000_1_0_00_100   // 24 release park
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 9, 10, 22: return "R2";
      2, 7, 11:        return "R5";
      3:               return "R9";
      4, 6, 12, 16, 17: return "R3";
      5, 13:           return "R6";
      8, 21:           return "R4";
      14, 15:          return "R9";
      18, 19, 23, 24:  return "R7";
      20:              return "R8";
      default:         return "R2";
    endcase
  endfunction

  task automatic check3(input string tag, input logic [2:0] exp);
    checks++;
    if ({req_n, start, park_en} !== exp) begin
      errors++;
      $display("FAIL %s: {req_n,start,park_en} actual %b expected %b", tag,
               {req_n, start, park_en}, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check3("R1", 3'b100);                  // reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      pw_cnt     = VEC[i][14:11];
      dr_cnt     = VEC[i][10:7];
      gnt_n      = VEC[i][6];
      term_valid = VEC[i][5];
      term_code  = VEC[i][4:3];
      @(posedge clk);
      @(negedge clk);
      check3(tag_of(i), VEC[i][2:0]);
    end
    term_valid = 1'b0;

    // R6: grant in the same cycle as a retry pulse, with work pending
    pw_cnt = 4'd3; gnt_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check3("R2", 3'b000);
    gnt_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check3("R5", 3'b010);
    term_valid = 1'b1; term_code = 2'd1;
    @(posedge clk); @(negedge clk);
    term_valid = 1'b0;
    check3("R6", 3'b100);
    @(posedge clk); @(negedge clk);
    check3("R3", 3'b101);

    // R1: reset while parked clears everything
    pw_cnt = '0;
    @(posedge clk); @(negedge clk);
    check3("R7", 3'b101);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check3("R1", 3'b100);
    rst = 1'b0; gnt_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check3("R1", 3'b100);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule